// File: doc/BRIEF.md
# Data Watchpoint Address Matcher

This block compares a stream of data accesses with one programmable watchpoint. Software sets up two 64-bit words through a small write port. The control word sets the enable, the access-type filter, the byte lanes, the region mask and the match sense. The value word holds the watched address.

Each cycle the block can take one access, made up of a valid flag, an address, a size in bytes and a load/store flag. One cycle later it raises a registered `hit` when the access satisfies the watchpoint.

There are two address modes. In the first, the watchpoint covers whole aligned regions of up to 2^31 bytes. In the second, it covers a contiguous set of byte lanes inside one doubleword. Any setting of the control word that is reserved or ill-formed turns the watchpoint off.

Top module: `dwp_matcher`

## Requirements
- R1: A write with `wr_sel`=0 loads the control word and one with `wr_sel`=1 loads the value word. Both load on the clock edge that samples `wr_en`. The new setting governs the access presented in the following cycle, not an access in the same cycle. Both registers read back on `ctrl_rd` and `value_rd`. Control bits [63:32], [23] and [21] always read back as zero. Reset clears both words.
- R2: Control bit 0 is the enable. While it is 0, `hit` stays low.
- R3: Control bits [4:3] filter on access type: 01 passes loads, 10 passes stores and 11 passes both. The value 00 turns the watchpoint off. `acc_store`=1 marks a store.
- R4: When the mask field is 0, control bits [12:5] select byte lanes. Bit k selects byte k of the doubleword that holds the watched address. The access address must lie in that same doubleword, compared on address bits [63:3].
- R5: When bit 2 of the value word is 1, only select bits [3:0] apply, and they address bytes 4 to 7 of the doubleword. Select bits [7:4] are then ignored.
- R6: When the mask field is 0, a select value that is zero or has non-contiguous set bits turns the watchpoint off.
- R7: Control bits [28:24] give a mask count N. When N is 3 to 31, the low N address bits are cleared on both sides before the compare, and the lane select is ignored.
- R8: A mask count of 1 or 2 is reserved and turns the watchpoint off.
- R9: Control bit 22 = 1 inverts the address result, so the watchpoint fires on a mismatch. Enable, type and reserved-setting rules still apply.
- R10: `hit` is registered. It reflects the access of the previous cycle, and it is 0 after a cycle with `acc_valid` low.
- R11: An access covers the bytes from `acc_addr` to `acc_addr`+`acc_size`-1, with a size of 1, 2, 4 or 8 and natural alignment. It matches in lane mode when any covered byte is a selected lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control word, 1 = value word |
| wr_data | input | 64 | Write data |
| ctrl_rd | output | 64 | Control word readback |
| value_rd | output | 64 | Value word readback |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 64 | Access address |
| acc_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| acc_store | input | 1 | 1 = store, 0 = load |
| hit | output | 1 | Registered watchpoint hit |

## Verification
The properties assume the access port carries only naturally aligned accesses of size 1, 2, 4 or 8. They also assume that a register write and the access it should affect are one cycle apart. The directed bench presents only aligned sizes. It places every address-sensitive access at least one cycle after the write that configures it, except in the one test that checks the same-cycle write case on purpose.

// File: rtl/dwp_matcher.sv
module dwp_matcher #(
  parameter int ADDR_W = 64,
  parameter int REG_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  ctrl_rd,
  output logic [REG_W-1:0]  value_rd,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [3:0]        acc_size,
  input  logic              acc_store,
  output logic              hit
);
  localparam int LANES  = 8;
  localparam int LANE_W = $clog2(LANES);
  localparam logic [REG_W-1:0] CTRL_WMASK = REG_W'(64'h0000_0000_FF5F_FFFF);

  logic [REG_W-1:0] ctrl_q, value_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      value_q <= '0;
    end else if (wr_en) begin
      if (wr_sel) value_q <= wr_data;
      else        ctrl_q  <= wr_data & CTRL_WMASK;
    end
  end

  assign ctrl_rd  = ctrl_q;
  assign value_rd = value_q;

  logic             en_f, mm_f;
  logic [1:0]       lsc_f;
  logic [LANES-1:0] bas_f;
  logic [4:0]       mask_f;

  assign en_f   = ctrl_q[0];
  assign lsc_f  = ctrl_q[4:3];
  assign bas_f  = ctrl_q[12:5];
  assign mm_f   = ctrl_q[22];
  assign mask_f = ctrl_q[28:24];

  logic [LANES:0] bas_x, bas_low, bas_sum;
  logic           bas_ok, mask_on, mask_rsvd, cfg_ok, type_ok;

  assign bas_x     = {1'b0, bas_f};
  assign bas_low   = bas_x & (~bas_x + 1'b1);
  assign bas_sum   = bas_x + bas_low;
  assign bas_ok    = (bas_f != '0) && ((bas_sum & bas_x) == '0);
  assign mask_on   = (mask_f != 5'd0);
  assign mask_rsvd = (mask_f == 5'd1) || (mask_f == 5'd2);
  assign cfg_ok    = en_f && (lsc_f != 2'b00) && !mask_rsvd && (mask_on || bas_ok);
  assign type_ok   = acc_store ? lsc_f[1] : lsc_f[0];

  logic [ADDR_W-1:0] val_a, low_mask;
  logic              region_eq, dword_eq, lane_eq, addr_match, hit_d;
  logic [LANES-1:0]  sel_lanes, size_lanes, acc_lanes;

  assign val_a     = value_q[ADDR_W-1:0];
  assign low_mask  = (ADDR_W'(1) << mask_f) - ADDR_W'(1);
  assign region_eq = (((acc_addr ^ val_a) & ~low_mask) == '0);
  assign dword_eq  = (acc_addr[ADDR_W-1:LANE_W] == val_a[ADDR_W-1:LANE_W]);
  assign sel_lanes = value_q[LANE_W-1] ? {bas_f[LANES/2-1:0], {(LANES/2){1'b0}}} : bas_f;

  always_comb begin
    case (acc_size)
      4'd1:    size_lanes = 8'h01;
      4'd2:    size_lanes = 8'h03;
      4'd4:    size_lanes = 8'h0F;
      4'd8:    size_lanes = 8'hFF;
      default: size_lanes = 8'h00;
    endcase
  end

  assign acc_lanes  = size_lanes << acc_addr[LANE_W-1:0];
  assign lane_eq    = dword_eq && ((sel_lanes & acc_lanes) != '0);
  assign addr_match = mask_on ? region_eq : lane_eq;
  assign hit_d      = acc_valid && cfg_ok && type_ok && (addr_match ^ mm_f);

  always_ff @(posedge clk) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= hit_d;
  end
endmodule

// File: rtl/dwp_matcher_chk.sv
module dwp_matcher_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [63:0] wr_data,
  input logic [63:0] ctrl_rd,
  input logic [63:0] value_rd,
  input logic        acc_valid,
  input logic        acc_store,
  input logic        hit
);
  assert_write_ctrl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (ctrl_rd[20:0] == $past(wr_data[20:0])) && (ctrl_rd[63:32] == '0)
                           && !ctrl_rd[23] && !ctrl_rd[21]);
  assert_write_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (value_rd == $past(wr_data)));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ctrl_rd) && $stable(value_rd)));
  assert_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd[0] |=> !hit);
  assert_type_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[4:3] == 2'b00) |=> !hit);
  assert_load_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[4:3] == 2'b01 && acc_store) |=> !hit);
  assert_store_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[4:3] == 2'b10 && !acc_store) |=> !hit);
  assert_mask_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[28:24] == 5'd1 || ctrl_rd[28:24] == 5'd2) |=> !hit);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !hit);
endmodule

bind dwp_matcher dwp_matcher_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ctrl_rd(ctrl_rd), .value_rd(value_rd), .acc_valid(acc_valid),
  .acc_store(acc_store), .hit(hit)
);

// File: tb/dwp_matcher_test.sv
module dwp_matcher_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] ctrl_rd, value_rd;
  logic        acc_valid = 1'b0;
  logic [63:0] acc_addr = '0;
  logic [3:0]  acc_size = 4'd1;
  logic        acc_store = 1'b0;
  logic        hit;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  localparam logic [63:0] V = 64'h0000_1234_5678_9A00;

  always #(CLK_P/2) clk = ~clk;

  dwp_matcher uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_rd(ctrl_rd), .value_rd(value_rd), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_store(acc_store), .hit(hit)
  );

  function automatic logic [63:0] mk(input logic en, input logic [1:0] lsc,
      input logic [7:0] bas, input logic [4:0] msk, input logic mm);
    mk = '0;
    mk[0] = en; mk[4:3] = lsc; mk[12:5] = bas; mk[28:24] = msk; mk[22] = mm;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic probe(input logic [63:0] a, input logic [3:0] sz, input logic st,
      input logic v, input logic e, input string tag);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_size = sz; acc_store = st;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(tag, {63'b0, hit}, {63'b0, e});
  endtask

  task automatic t_reset;
    chk("R1 reset ctrl", ctrl_rd, 64'h0);
    chk("R1 reset value", value_rd, 64'h0);
    chk("R10 reset hit", {63'b0, hit}, 64'h0);
  endtask

  task automatic t_readback;
    wr(1'b0, '1);
    chk("R1 ctrl reserved bits zero", ctrl_rd, 64'h0000_0000_FF5F_FFFF);
    wr(1'b1, 64'hDEAD_BEEF_0123_4567);
    chk("R1 value readback", value_rd, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_enable;
    wr(1'b1, V);
    wr(1'b0, mk(1'b0, 2'b11, 8'h01, 5'd0, 1'b0));
    probe(V, 4'd1, 1'b0, 1'b1, 1'b0, "R2 disabled");
    wr(1'b0, mk(1'b1, 2'b11, 8'h01, 5'd0, 1'b0));
    probe(V, 4'd1, 1'b0, 1'b1, 1'b1, "R2 enabled");
  endtask

  task automatic t_type;
    wr(1'b0, mk(1'b1, 2'b01, 8'h01, 5'd0, 1'b0));
    probe(V, 4'd1, 1'b0, 1'b1, 1'b1, "R3 load-only load");
    probe(V, 4'd1, 1'b1, 1'b1, 1'b0, "R3 load-only store");
    wr(1'b0, mk(1'b1, 2'b10, 8'h01, 5'd0, 1'b0));
    probe(V, 4'd1, 1'b0, 1'b1, 1'b0, "R3 store-only load");
    probe(V, 4'd1, 1'b1, 1'b1, 1'b1, "R3 store-only store");
    wr(1'b0, mk(1'b1, 2'b00, 8'h01, 5'd0, 1'b0));
    probe(V, 4'd1, 1'b0, 1'b1, 1'b0, "R3 type 00 load");
    probe(V, 4'd1, 1'b1, 1'b1, 1'b0, "R3 type 00 store");
  endtask

  task automatic t_lanes;
    wr(1'b1, V);
    wr(1'b0, mk(1'b1, 2'b11, 8'h30, 5'd0, 1'b0));
    probe(V + 4, 4'd1, 1'b0, 1'b1, 1'b1, "R4 lane 4 hit");
    probe(V + 3, 4'd1, 1'b0, 1'b1, 1'b0, "R4 lane 3 miss");
    probe(V + 8, 4'd1, 1'b0, 1'b1, 1'b0, "R4 next doubleword miss");
    probe(V + 6, 4'd2, 1'b0, 1'b1, 1'b0, "R11 halfword lanes 6-7 miss");
    probe(V + 4, 4'd4, 1'b1, 1'b1, 1'b1, "R11 word lanes 4-7 hit");
    probe(V, 4'd8, 1'b0, 1'b1, 1'b1, "R11 doubleword overlaps");
    probe(V, 4'd4, 1'b0, 1'b1, 1'b0, "R11 word lanes 0-3 miss");
  endtask

  task automatic t_word_mode;
    wr(1'b1, V + 4);
    wr(1'b0, mk(1'b1, 2'b11, 8'h01, 5'd0, 1'b0));
    probe(V + 4, 4'd1, 1'b0, 1'b1, 1'b1, "R5 byte at word base");
    probe(V, 4'd1, 1'b0, 1'b1, 1'b0, "R5 byte 0 not selected");
    probe(V, 4'd8, 1'b0, 1'b1, 1'b1, "R5 doubleword covers word");
    wr(1'b0, mk(1'b1, 2'b11, 8'h10, 5'd0, 1'b0));
    probe(V, 4'd8, 1'b0, 1'b1, 1'b0, "R5 upper select ignored");
  endtask

  task automatic t_bad_select;
    wr(1'b1, V);
    wr(1'b0, mk(1'b1, 2'b11, 8'h05, 5'd0, 1'b0));
    probe(V, 4'd8, 1'b0, 1'b1, 1'b0, "R6 non-contiguous select");
    wr(1'b0, mk(1'b1, 2'b11, 8'h00, 5'd0, 1'b0));
    probe(V, 4'd8, 1'b0, 1'b1, 1'b0, "R6 zero select");
    wr(1'b0, mk(1'b1, 2'b11, 8'h00, 5'd0, 1'b1));
    probe(V + 64, 4'd8, 1'b0, 1'b1, 1'b0, "R6 zero select mismatch mode");
  endtask

  task automatic t_mask;
    wr(1'b1, 64'h0000_00AB_CDEF_5000);
    wr(1'b0, mk(1'b1, 2'b11, 8'h00, 5'd12, 1'b0));
    probe(64'h0000_00AB_CDEF_5FF8, 4'd8, 1'b0, 1'b1, 1'b1, "R7 inside 4K region");
    probe(64'h0000_00AB_CDEF_6000, 4'd1, 1'b0, 1'b1, 1'b0, "R7 above region");
    probe(64'h0000_00AB_CDEF_4FFF, 4'd1, 1'b0, 1'b1, 1'b0, "R7 below region");
    wr(1'b1, 64'h0000_0001_8000_0000);
    wr(1'b0, mk(1'b1, 2'b11, 8'h05, 5'd31, 1'b0));
    probe(64'h0000_0001_FFFF_FFF8, 4'd8, 1'b0, 1'b1, 1'b1, "R7 mask 31 inside");
    probe(64'h0000_0001_7FFF_FFF8, 4'd8, 1'b0, 1'b1, 1'b0, "R7 mask 31 outside");
  endtask

  task automatic t_mask_rsvd;
    wr(1'b1, V);
    wr(1'b0, mk(1'b1, 2'b11, 8'h01, 5'd1, 1'b0));
    probe(V, 4'd1, 1'b0, 1'b1, 1'b0, "R8 mask 1 reserved");
    wr(1'b0, mk(1'b1, 2'b11, 8'h01, 5'd2, 1'b0));
    probe(V, 4'd1, 1'b0, 1'b1, 1'b0, "R8 mask 2 reserved");
    wr(1'b0, mk(1'b1, 2'b11, 8'h01, 5'd3, 1'b0));
    probe(V + 7, 4'd1, 1'b0, 1'b1, 1'b1, "R7 mask 3 covers 8 bytes");
  endtask

  task automatic t_mismatch;
    wr(1'b1, V);
    wr(1'b0, mk(1'b1, 2'b11, 8'h01, 5'd0, 1'b1));
    probe(V, 4'd1, 1'b0, 1'b1, 1'b0, "R9 mismatch on watched byte");
    probe(V + 1, 4'd1, 1'b0, 1'b1, 1'b1, "R9 mismatch other lane");
    probe(V + 8, 4'd1, 1'b0, 1'b1, 1'b1, "R9 mismatch other doubleword");
    wr(1'b0, mk(1'b1, 2'b10, 8'h01, 5'd0, 1'b1));
    probe(V + 8, 4'd1, 1'b0, 1'b1, 1'b0, "R9 mismatch type filter");
    wr(1'b0, mk(1'b1, 2'b11, 8'h00, 5'd12, 1'b1));
    probe(V + 8, 4'd1, 1'b0, 1'b1, 1'b0, "R9 mismatch inside region");
    probe(V + 64'h1000, 4'd1, 1'b0, 1'b1, 1'b1, "R9 mismatch outside region");
  endtask

  task automatic t_idle;
    wr(1'b1, V);
    wr(1'b0, mk(1'b1, 2'b11, 8'hFF, 5'd0, 1'b0));
    probe(V, 4'd8, 1'b0, 1'b0, 1'b0, "R10 invalid access no hit");
    probe(V, 4'd8, 1'b0, 1'b1, 1'b1, "R10 valid access hit");
    @(negedge clk);
    chk("R10 hit drops after idle", {63'b0, hit}, 64'h0);
  endtask

  task automatic t_timing;
    wr(1'b0, 64'h0);
    wr(1'b1, V);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = mk(1'b1, 2'b11, 8'h01, 5'd0, 1'b0);
    acc_valid = 1'b1; acc_addr = V; acc_size = 4'd1; acc_store = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R1 same-cycle write not applied", {63'b0, hit}, 64'h0);
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R1 write applies next cycle", {63'b0, hit}, 64'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_readback;
    t_enable;
    t_type;
    t_lanes;
    t_word_mode;
    t_bad_select;
    t_mask;
    t_mask_rsvd;
    t_mismatch;
    t_idle;
    t_timing;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule